// File: doc/BRIEF.md
# Supply Supervisor with Reset Stretch

This block supervises the supply of a battery-backed static memory. It receives three comparator results that are already synchronised to the clock. They report whether the supply is above an upper run threshold, above a lower protect threshold, and above a low switchover level. The three levels are ordered, with run above protect above switchover. From these inputs the block produces a write-protect / bus-release signal, an open-drain processor reset modelled as an active-low drive enable, and a select that powers the memory from the backup cell.

Normal operation is entered only after the supply has stayed above the upper threshold for a stretch of timebase ticks. It is left as soon as the supply falls below the lower threshold. Between the two thresholds a running system stays running, which gives the block its hysteresis. A one-shot seal keeps the backup cell disconnected until the supply has first reached the protect level. A comparator combination that the level ordering forbids is flagged, and the block is forced into protection.

Top module: `supply_supervisor`

## Requirements
- R1: After the synchronous reset, protect_o is 1, rst_pull_n is 0, bkup_sel_o is 0, cell_en_o is 0 and cmp_err_o is 0.
- R2: While running, a clock edge that samples above_lo=0 sets protect_o to 1 and rst_pull_n to 0 from that edge on. A running block that samples above_lo=1, above_hi=0 stays running, because the upper level is needed only to resume.
- R3: The block leaves protection only into the reset hold. It enters the hold only on an edge that samples above_hi=1. An edge in the hold that samples above_hi=0 returns it to protection, and the next hold counts again from zero.
- R4: The hold counts only the edges where tick=1. Reset is released (rst_pull_n=1, protect_o=0) on the edge that counts the HOLD_TICKS-th such tick after the edge that entered the hold.
- R5: On a consistent edge with above_sw=0, the block enters backup. In backup, bkup_sel_o equals cell_en_o and protect_o stays 1. The first edge with above_sw=1 returns it to protection with bkup_sel_o=0.
- R6: cell_en_o stays 0 until an edge samples the consistent combination above_lo=1. It is 1 from that edge on, whatever the inputs, until the synchronous reset.
- R7: On an edge that samples above_hi=1 with above_lo=0, or above_lo=1 with above_sw=0, cmp_err_o becomes 1 and the block goes to protection with bkup_sel_o=0. cmp_err_o returns to 0 on the next consistent edge.
- R8: protect_o is 1 exactly when rst_pull_n is 0, so reset is driven whenever memory access is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restores the shipping state |
| tick | input | 1 | Timebase strobe for the reset hold |
| above_hi | input | 1 | Supply above the run threshold |
| above_lo | input | 1 | Supply above the protect threshold |
| above_sw | input | 1 | Supply above the backup switchover level |
| protect_o | output | 1 | 1: writes blocked, inputs ignored, memory outputs released |
| rst_pull_n | output | 1 | 0: reset line actively pulled low |
| bkup_sel_o | output | 1 | 1: memory powered from the backup cell |
| cell_en_o | output | 1 | 1: backup cell connected (seal released) |
| cmp_err_o | output | 1 | 1: last sample was an impossible level combination |

## Verification
On every cycle, the bound assertions check several properties. Protect and reset always agree. A low protect comparator always leads to protection on the next cycle. The seal never closes again. Backup selection only occurs with the seal open. Every release of reset follows a sample taken above the upper threshold and on a tick. The bench scenarios cover what the assertions cannot: the exact length of the hold, its restart after a dip, the counting of gated ticks, hysteresis between the thresholds, and the seal state before and after the first power-up.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_BKUP = 2'd0,
        ST_PROT = 2'd1,
        ST_HOLD = 2'd2,
        ST_RUN  = 2'd3
    } sup_state_e;

    typedef struct packed {
        logic sw;
        logic lo;
        logic hi;
    } sup_lvl_t;

    // Levels are ordered hi > lo > sw; any other pattern is impossible.
    function automatic logic lvl_consistent(sup_lvl_t l);
        return !(l.hi && !l.lo) && !(l.lo && !l.sw);
    endfunction

    function automatic sup_state_e next_state(sup_state_e cur, sup_lvl_t l,
                                              logic ok, logic hold_done);
        sup_state_e nxt;
        nxt = cur;
        if (!ok) begin
            nxt = ST_PROT;
        end else if (!l.sw) begin
            nxt = ST_BKUP;
        end else begin
            unique case (cur)
                ST_BKUP: nxt = ST_PROT;
                ST_PROT: nxt = l.hi ? ST_HOLD : ST_PROT;
                ST_HOLD: nxt = !l.hi ? ST_PROT : (hold_done ? ST_RUN : ST_HOLD);
                ST_RUN:  nxt = !l.lo ? ST_PROT : ST_RUN;
                default: nxt = ST_PROT;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/sup_level_check.sv
module sup_level_check
    import sup_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sup_lvl_t lvl,
    output logic     ok,
    output logic     err_q
);
    assign ok = lvl_consistent(lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= !ok;
        end
    end
endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
    parameter int HOLD_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sup_seal_latch.sv
module sup_seal_latch (
    input  logic clk,
    input  logic rst,
    input  logic first_power,
    output logic open_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (first_power) begin
            open_q <= 1'b1;
        end
    end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
    import sup_pkg::*;
#(
    parameter int HOLD_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic above_hi,
    input  logic above_lo,
    input  logic above_sw,
    output logic protect_o,
    output logic rst_pull_n,
    output logic bkup_sel_o,
    output logic cell_en_o,
    output logic cmp_err_o
);
    sup_lvl_t   lvl;
    sup_state_e state_q;
    sup_state_e state_d;
    logic       lvl_ok;
    logic       hold_done;
    logic       seal_open;

    assign lvl = '{sw: above_sw, lo: above_lo, hi: above_hi};

    sup_level_check u_check (
        .clk   (clk),
        .rst   (rst),
        .lvl   (lvl),
        .ok    (lvl_ok),
        .err_q (cmp_err_o)
    );

    sup_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == ST_HOLD),
        .tick (tick),
        .done (hold_done)
    );

    sup_seal_latch u_seal (
        .clk         (clk),
        .rst         (rst),
        .first_power (lvl_ok && above_lo),
        .open_q      (seal_open)
    );

    assign state_d = next_state(state_q, lvl, lvl_ok, hold_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PROT;
        end else begin
            state_q <= state_d;
        end
    end

    assign protect_o  = (state_q != ST_RUN);
    assign rst_pull_n = (state_q == ST_RUN);
    assign bkup_sel_o = (state_q == ST_BKUP) && seal_open;
    assign cell_en_o  = seal_open;
endmodule

// File: rtl/supply_supervisor_chk.sv
module supply_supervisor_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic above_hi,
    input logic above_lo,
    input logic above_sw,
    input logic protect_o,
    input logic rst_pull_n,
    input logic bkup_sel_o,
    input logic cell_en_o,
    input logic cmp_err_o
);
    assert_prot_rst_agree_R8: assert property (@(posedge clk) disable iff (rst)
        protect_o == !rst_pull_n);

    assert_drop_protects_R2: assert property (@(posedge clk) disable iff (rst)
        !above_lo |=> protect_o);

    assert_release_needs_hi_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_pull_n) |-> $past(above_hi));

    assert_release_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_pull_n) |-> $past(tick));

    assert_bkup_needs_seal_R5: assert property (@(posedge clk) disable iff (rst)
        bkup_sel_o |-> (cell_en_o && protect_o));

    assert_seal_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        cell_en_o |=> cell_en_o);

    assert_bad_combo_R7: assert property (@(posedge clk) disable iff (rst)
        ((above_hi && !above_lo) || (above_lo && !above_sw)) |=>
        (cmp_err_o && protect_o && !bkup_sel_o));
endmodule

bind supply_supervisor supply_supervisor_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .above_hi   (above_hi),
    .above_lo   (above_lo),
    .above_sw   (above_sw),
    .protect_o  (protect_o),
    .rst_pull_n (rst_pull_n),
    .bkup_sel_o (bkup_sel_o),
    .cell_en_o  (cell_en_o),
    .cmp_err_o  (cmp_err_o)
);

// File: tb/supply_supervisor_tb_top.sv
module supply_supervisor_tb_top;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic above_hi = 1'b0;
    logic above_lo = 1'b0;
    logic above_sw = 1'b0;
    logic protect_o, rst_pull_n, bkup_sel_o, cell_en_o, cmp_err_o;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    supply_supervisor #(.HOLD_TICKS(N)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .above_hi   (above_hi),
        .above_lo   (above_lo),
        .above_sw   (above_sw),
        .protect_o  (protect_o),
        .rst_pull_n (rst_pull_n),
        .bkup_sel_o (bkup_sel_o),
        .cell_en_o  (cell_en_o),
        .cmp_err_o  (cmp_err_o)
    );

    // inputs {sw,lo,hi}, then expected {protect, rst_pull_n, bkup, err, cell_en}; tick held 0
    localparam int NV = 11;
    localparam logic [7:0] VEC [NV] = '{
        8'b000_10000,  // below switchover, seal closed: no backup
        8'b100_10000,  // back to protection
        8'b110_10001,  // protect level reached: seal opens
        8'b000_10101,  // backup with seal open
        8'b001_10011,  // impossible hi without lo
        8'b010_10011,  // impossible lo without sw
        8'b111_10001,  // into hold, no ticks
        8'b110_10001,  // dip below upper: back to protection
        8'b100_10001,
        8'b000_10101,  // backup again, seal stays open
        8'b100_10001   // switchover back to external supply
    };

    function automatic logic [4:0] outs();
        return {protect_o, rst_pull_n, bkup_sel_o, cmp_err_o, cell_en_o};
    endfunction

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic sw, input logic lo, input logic hi, input logic tk);
        @(negedge clk);
        above_sw = sw; above_lo = lo; above_hi = hi; tick = tk;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; above_sw = 0; above_lo = 0; above_hi = 0; tick = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // bring block from protection to run with tick every cycle
    task automatic power_up();
        step(1, 1, 1, 1);
        for (int i = 0; i < N; i++) step(1, 1, 1, 1);
    endtask

    initial begin
        #1500000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk("R1 reset state", outs(), 5'b10000);

        for (int v = 0; v < NV; v++) begin
            step(VEC[v][7], VEC[v][6], VEC[v][5], 1'b0);
            chk($sformatf("R5/R6/R7 vector %0d", v), outs(), VEC[v][4:0]);
        end

        // R4: exact hold length with tick every cycle
        step(1, 1, 1, 1);
        for (int i = 0; i < N - 1; i++) step(1, 1, 1, 1);
        chk("R4 still held before last tick", outs(), 5'b10001);
        step(1, 1, 1, 1);
        chk("R4 released on last tick", outs(), 5'b01001);

        // R2: hysteresis between thresholds keeps running
        step(1, 1, 0, 1);
        chk("R2 stays running between thresholds", outs(), 5'b01001);
        step(1, 0, 0, 1);
        chk("R2 below lower level protects", outs(), 5'b10001);

        // R3: dip during hold restarts count
        step(1, 1, 1, 1);
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1);
        step(1, 1, 0, 1);
        chk("R3 dip during hold protects", outs(), 5'b10001);
        step(1, 1, 1, 1);
        for (int i = 0; i < N - 1; i++) step(1, 1, 1, 1);
        chk("R3 hold restarted from zero", outs(), 5'b10001);
        step(1, 1, 1, 1);
        chk("R3 released after full restarted hold", outs(), 5'b01001);

        // R5: sudden drop from run straight to backup, then return
        step(0, 0, 0, 1);
        chk("R5 run to backup", outs(), 5'b10101);
        step(1, 0, 0, 1);
        chk("R5 back to external supply", outs(), 5'b10001);

        // R4: only gated ticks count
        step(1, 1, 1, 0);
        for (int i = 0; i < 2 * N - 1; i++) step(1, 1, 1, (i % 2) == 1);
        chk("R4 gated ticks still held", outs(), 5'b10001);
        step(1, 1, 1, 1);
        chk("R4 gated ticks released", outs(), 5'b01001);

        // R7: impossible combo from run forces protection, clears after
        step(1, 0, 1, 1);
        chk("R7 error from run", outs(), 5'b10011);
        step(1, 1, 0, 1);
        chk("R7 error clears on consistent sample", outs(), 5'b10001);

        // R8: agreement sampled in run and protection
        power_up();
        chk("R8 run: protect low and reset released", {protect_o, rst_pull_n}, 2'b01);
        step(1, 0, 0, 0);
        chk("R8 protect: reset driven", {protect_o, rst_pull_n}, 2'b10);

        // R6: reset restores closed seal; first power opens it
        do_reset();
        #1;
        chk("R6 seal closed after reset", outs(), 5'b10000);
        step(0, 0, 0, 0);
        chk("R6 backup level before first power: cell off", outs(), 5'b10000);
        step(1, 0, 0, 0);
        chk("R6 switchover level does not open seal", outs(), 5'b10000);
        step(1, 1, 0, 0);
        chk("R6 protect level opens seal", outs(), 5'b10001);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule